// File: doc/BRIEF.md
# Blocking Counting Semaphore Cell

This block is one semaphore cell of an inter-thread synchronisation unit. It holds a 16-bit count. Threads take from it through a P port, which acts like a read, and give to it through a V port, which acts like a write. A P access returns the count as it stood and takes one unit when the count is above zero. A V access adds one unit, stopping at the count's maximum, and ignores the data that comes with it.

A P access may be blocking or non-blocking. When a blocking P finds nothing to take, the cell signals a stall in that same cycle. It also records the caller's 6-bit thread number in a 64-bit parked-thread mask, so the core can halt that thread and retry the access later. Every V that reaches the cell releases all parked threads at once. It does this with a one-cycle wake pulse that carries the whole mask, and then it empties the mask.

A P and a V may arrive in the same cycle. The V is applied first. When the cell's owner has set it to queue mode, it stops acting as a semaphore: P returns zero and V has no effect.

Top module: `sem_cell`

## Requirements
- R1: A P access (p_req high, fifo_mode low) returns on p_rdata, in the same cycle, the count before the access, zero-extended to 64 bits. If that count is above zero, the count is one lower from the next cycle. When p_req is low, p_rdata is 0.
- R2: A blocking P (p_block high) at count 0 raises p_stall in the same cycle. Bit p_tid of the parked mask is set and the count stays 0. p_stall is never high in a cycle whose P takes a unit.
- R3: A non-blocking P (p_block low) at count 0 returns 0, leaves p_stall low and changes nothing.
- R4: A V access (v_req high, fifo_mode low) raises the count by one unless the count is already 0xFFFF, in which case the count stays 0xFFFF. The value of v_wdata and the level of v_block have no effect.
- R5: In the cycle after a V, wake equals the parked mask as it stood before that V, and the mask becomes empty. wake is zero in every cycle that does not follow a V. A V with an empty mask therefore produces no wake.
- R6: When V and P arrive in the same cycle, V is applied first. P returns the incremented value (saturated at 0xFFFF) and takes from it, so a blocking P that arrives together with a V at count 0 does not stall.
- R7: While fifo_mode is high, P returns 0 and never stalls, V does nothing, the count and the parked mask keep their values, and no wake is raised.
- R8: After reset the count is 0, the parked mask is empty and wake is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | Cell is set to queue mode; semaphore accesses have no effect |
| p_req | input | 1 | P (take) access this cycle |
| p_block | input | 1 | P access is blocking |
| p_tid | input | 6 | Thread number of the P caller |
| p_rdata | output | 64 | Count before the P access, zero-extended |
| p_stall | output | 1 | Blocking P found zero; the caller is parked |
| v_req | input | 1 | V (give) access this cycle |
| v_block | input | 1 | Blocking form of V; behaves the same as non-blocking |
| v_wdata | input | 64 | Write data of the V access; ignored |
| wake | output | 64 | One-cycle pulse, one bit per released thread |

## Verification
The bench drives the cell up to the 0xFFFF limit and one step past it. A design that wraps would then return 0 or 1 on the next P instead of 0xFFFF. It also parks the lowest and the highest thread numbers and checks that a single V releases both and empties the mask. A design that cleared one bit, or that left the mask standing, would show a second wake on the next V. A V paired with a blocking P at zero must return 1 without a stall; a design that orders P first would stall and park that thread. A parked thread must survive queue-mode traffic and still be woken afterwards; a design that lets V act in queue mode would lose it early.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // Add one unless the value already sits at the limit.
  function automatic logic [31:0] sat_inc(input logic [31:0] val, input logic [31:0] lim);
    return (val == lim) ? val : val + 32'd1;
  endfunction

  // Take one unless the value is already zero.
  function automatic logic [31:0] floor_dec(input logic [31:0] val);
    return (val == 32'd0) ? val : val - 32'd1;
  endfunction

endpackage

// File: rtl/sem_count.sv
module sem_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_fire,
  input  logic             p_take,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_after_v
);
  import sem_pkg::*;

  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [31:0] inc_w;
  logic [31:0] dec_w;

  assign inc_w       = sat_inc(32'(count), CNT_MAX);
  assign cnt_after_v = v_fire ? inc_w[CNT_W-1:0] : count;
  assign dec_w       = floor_dec(32'(cnt_after_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (p_take) begin
      count <= dec_w[CNT_W-1:0];
    end else begin
      count <= cnt_after_v;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !v_fire) |=> count == '0); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX[CNT_W-1:0] && !p_take) |=> count == CNT_MAX[CNT_W-1:0]); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_fire && !p_take) |=> $stable(count)); // R7

endmodule

// File: rtl/sem_park.sv
module sem_park #(
  parameter int TID_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  v_fire,
  input  logic                  p_park,
  input  logic [TID_W-1:0]      p_tid,
  output logic [(1<<TID_W)-1:0] mask,
  output logic [(1<<TID_W)-1:0] wake
);
  localparam int NTHR = 1 << TID_W;

  logic [NTHR-1:0] tid_bit;
  logic [NTHR-1:0] mask_nxt;

  always_comb begin
    tid_bit        = '0;
    tid_bit[p_tid] = 1'b1;
    mask_nxt       = v_fire ? '0 : mask;
    if (p_park) mask_nxt = mask_nxt | tid_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      wake <= '0;
    end else begin
      mask <= mask_nxt;
      wake <= v_fire ? mask : '0;
    end
  end

  AST_WAKE_AFTER_V: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != '0) |-> $past(v_fire)); // R5
  AST_MASK_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    v_fire |=> mask == '0); // R5
  AST_PARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    p_park |=> mask[$past(p_tid)]); // R2

endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int CNT_W  = 16,
  parameter int TID_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_mode,
  input  logic                  p_req,
  input  logic                  p_block,
  input  logic [TID_W-1:0]      p_tid,
  output logic [DATA_W-1:0]     p_rdata,
  output logic                  p_stall,
  input  logic                  v_req,
  input  logic                  v_block,
  input  logic [DATA_W-1:0]     v_wdata,
  output logic [(1<<TID_W)-1:0] wake
);
  localparam int NTHR  = 1 << TID_W;
  localparam int PAD_W = DATA_W - CNT_W;

  // Named internal events
  logic             p_act;
  logic             v_fire;
  logic             p_take;
  logic             p_park;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cnt_after_v;
  logic [NTHR-1:0]  mask;

  assign p_act  = p_req && !fifo_mode;
  assign v_fire = v_req && !fifo_mode;
  assign p_take = p_act && (cnt_after_v != '0);
  assign p_park = p_act && p_block && (cnt_after_v == '0);

  sem_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .v_fire      (v_fire),
    .p_take      (p_take),
    .count       (count),
    .cnt_after_v (cnt_after_v)
  );

  sem_park #(.TID_W(TID_W)) u_park (
    .clk    (clk),
    .rst_n  (rst_n),
    .v_fire (v_fire),
    .p_park (p_park),
    .p_tid  (p_tid),
    .mask   (mask),
    .wake   (wake)
  );

  assign p_rdata = p_act ? {{PAD_W{1'b0}}, cnt_after_v} : '0;
  assign p_stall = p_park;

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    p_stall |-> !p_take); // R2
  AST_STALL_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    p_stall |=> count == '0); // R2
  AST_QUEUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |-> (p_rdata == '0 && !p_stall)); // R7
  AST_QUEUE_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> $stable(mask)); // R7
  AST_V_BEFORE_P: assert property (@(posedge clk) disable iff (!rst_n)
    (v_fire && p_act) |-> !p_stall); // R6
  AST_V_INPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    v_req |-> !$isunknown({v_block, v_wdata})); // R4
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && mask == '0 && wake == '0)); // R8

endmodule

// File: tb/sim_sem_cell.sv
`timescale 1ns/1ps
module sim_sem_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0;
  logic        p_req = 1'b0;
  logic        p_block = 1'b0;
  logic [5:0]  p_tid = '0;
  logic [63:0] p_rdata;
  logic        p_stall;
  logic        v_req = 1'b0;
  logic        v_block = 1'b0;
  logic [63:0] v_wdata = '0;
  logic [63:0] wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int          ref_cnt  = 0;
  logic [63:0] ref_mask = '0;
  logic [63:0] ref_wake = '0;

  always #10 clk = ~clk;

  sem_cell u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .p_req(p_req), .p_block(p_block), .p_tid(p_tid),
    .p_rdata(p_rdata), .p_stall(p_stall),
    .v_req(v_req), .v_block(v_block), .v_wdata(v_wdata),
    .wake(wake)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; compares just before the edge, updates the model after it.
  task automatic cyc(input bit p, input bit pb, input int tid, input bit v, input bit vb,
                     input logic [63:0] vd, input bit fm, input string tag);
    int eff;
    bit stall_e;
    logic [63:0] rd_e;
    logic [63:0] wake_n;
    p_req = p; p_block = pb; p_tid = 6'(tid);
    v_req = v; v_block = vb; v_wdata = vd; fifo_mode = fm;
    #17;
    eff = ref_cnt;
    if (!fm && v && eff < 65535) eff = eff + 1;
    rd_e    = (p && !fm) ? 64'(eff) : 64'd0;
    stall_e = p && pb && !fm && (eff == 0);
    chk(tag, "p_rdata", p_rdata, rd_e);
    chk(tag, "p_stall", {63'd0, p_stall}, {63'd0, stall_e});
    chk(tag, "wake", wake, ref_wake);
    @(posedge clk);
    #1;
    wake_n = (!fm && v) ? ref_mask : 64'd0;
    if (!fm) begin
      if (v) ref_mask = '0;
      if (p && eff > 0) eff = eff - 1;
      ref_cnt = eff;
      if (stall_e) ref_mask[tid] = 1'b1;
    end
    ref_wake = wake_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8: clean state after reset
    cyc(0, 0, 0, 0, 0, 64'd0, 0, "R8");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R8");
    // R3: non-blocking P at zero
    cyc(1, 0, 7, 0, 0, 64'd0, 0, "R3");
    // R4: V with assorted data and blocking flag
    cyc(0, 0, 0, 1, 0, 64'hDEAD_BEEF_0000_0005, 0, "R4");
    cyc(0, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4");
    cyc(0, 0, 0, 1, 0, 64'd0, 0, "R4");
    // R1: P returns pre-access value and takes one
    cyc(1, 1, 1, 0, 0, 64'd0, 0, "R1");
    cyc(1, 0, 1, 0, 0, 64'd0, 0, "R1");
    cyc(1, 1, 1, 0, 0, 64'd0, 0, "R1");
    cyc(1, 0, 1, 0, 0, 64'd0, 0, "R1");
    // R2: blocking P at zero parks threads 5, 63, 0
    cyc(1, 1, 5, 0, 0, 64'd0, 0, "R2");
    cyc(1, 1, 63, 0, 0, 64'd0, 0, "R2");
    cyc(1, 1, 0, 0, 0, 64'd0, 0, "R2");
    // R5: V releases everything at once, then empty mask gives no wake
    cyc(0, 0, 0, 1, 0, 64'd3, 0, "R5");
    cyc(0, 0, 0, 1, 1, 64'd9, 0, "R5");
    cyc(0, 0, 0, 0, 0, 64'd0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R5");
    // R6: V and blocking P together at zero
    cyc(1, 1, 12, 1, 0, 64'd0, 0, "R6");
    cyc(1, 0, 12, 0, 0, 64'd0, 0, "R6");
    // R7: park thread 9, then queue-mode traffic must be inert
    cyc(1, 1, 9, 0, 0, 64'd0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 64'd1, 1, "R7");
    cyc(1, 1, 4, 0, 0, 64'd0, 1, "R7");
    cyc(1, 1, 4, 1, 1, 64'd2, 1, "R7");
    cyc(0, 0, 0, 0, 0, 64'd0, 1, "R7");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 64'd0, 0, "R7");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 64'd0, 0, "R7");
    // R4: saturation at 0xFFFF and one step past it
    for (int i = 0; i < 65536; i++) cyc(0, 0, 0, 1, i[0], 64'(i), 0, "R4");
    cyc(1, 0, 0, 0, 0, 64'd0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 64'd0, 0, "R4");
    // R6: V and P together at the limit
    cyc(1, 1, 2, 1, 0, 64'd0, 0, "R6");
    cyc(1, 0, 2, 0, 0, 64'd0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 64'd0, 0, "R6");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule